// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block sits between eight asynchronous interrupt pins and a parent interrupt controller. Software picks a sense mode for each pin: low level, falling edge, rising edge or both edges. The block turns every mode into one active-high, level-sensitive request per pin, which is what the parent expects.

Level-mode pending bits follow the synchronized pin and drop by themselves when the pin returns high. Edge-mode events are latched and held until software clears them. Clearing is a two-step handshake on the status register: software first reads the register, then writes it with a zero in the bit to clear and ones elsewhere. An edge that arrives between the read and the write stays latched, so no event is lost.

The register port is 16 bits wide and uses a one-cycle strobe for reads and for writes. Read data appears one cycle after the strobe.

Top module: `extint_sense_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `irq_req` is 0 and `reg_rdata` is 0. After reset, the configuration register reads 0x0000 (every pin in low-level mode) and the status register reads 0x0000.
- R2: The configuration register is at byte offset 0x0. Pin n uses bits [2n+1:2n], coded 00 = low level, 01 = falling edge, 10 = rising edge, 11 = both edges. A write stores all 16 bits, and a read returns them unchanged, so read-modify-write of one field leaves the others as they were.
- R3: In low-level mode a pin is pending while its synchronized value is 0. Pending drops without any register access once the synchronized value is 1.
- R4: In an edge mode, the selected transition of the synchronized pin latches the pin's status bit. Transitions that the mode does not select latch nothing. A transition is found by comparing the synchronized value with its value one cycle earlier.
- R5: A status write with a 1 in a bit position leaves that latched bit unchanged.
- R6: A status write with a 0 clears a latched bit only if a status read since the previous status write returned that bit as 1. An edge latched after that read survives the write.
- R7: Writing a new sense mode does not clear an edge status bit that is already latched.
- R8: `irq_req[n]` is 1 exactly one cycle after pin n is pending (latched edge bit or active low level), and is 0 otherwise.
- R9: The status register is at byte offset 0x2. It returns the live pending bits in [7:0] and zeros in [15:8]. A read of any other offset returns 0, and a write to any other offset has no effect. `reg_rdata` is updated one cycle after a read strobe and holds its value otherwise.
- R10: Each pin passes through two synchronizer flops. The synchronizer and the previous-value stage reset to 1, so pins held high through reset produce no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register byte offset (0x0 configuration, 0x2 status) |
| reg_rd | input | 1 | Read strobe, one cycle |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| pin_in | input | 8 | Asynchronous external interrupt pins |
| irq_req | output | 8 | Level-high requests to the parent controller |

## Verification
The bench builds the block with its default parameters: eight pins, a 16-bit data path and a 2-bit offset. At this size every sense field fills the configuration word, so a read-modify-write on the topmost field and reads of both the unused status byte and an unmapped offset can be exercised. A behavioural model follows the synchronizer latency and the read-then-clear handshake every cycle. This makes edges that land between a status read and the following write, and mode changes made with a bit already latched, observable at the ports.

// File: rtl/extint_pkg.sv
package extint_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] prev
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] cur_q;
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '1;
      cur_q  <= '1;
      prev_q <= '1;
    end else begin
      meta_q <= async_in;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur  = cur_q;
  assign prev = prev_q;
endmodule

// File: rtl/extint_sense_cell.sv
module extint_sense_cell
  import extint_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       cur,
  input  logic       prev,
  input  logic       clr,
  output logic       flag,
  output logic       pending
);
  logic rise, fall, hit, level_on;
  logic flag_q;

  always_comb begin
    rise     = cur & ~prev;
    fall     = ~cur & prev;
    hit      = 1'b0;
    level_on = 1'b0;
    case (sense_e'(mode))
      SENSE_LOW:  level_on = ~cur;
      SENSE_FALL: hit = fall;
      SENSE_RISE: hit = rise;
      SENSE_BOTH: hit = rise | fall;
      default:    hit = 1'b0;
    endcase
  end

  // a new edge wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst)      flag_q <= 1'b0;
    else if (hit) flag_q <= 1'b1;
    else if (clr) flag_q <= 1'b0;
  end

  assign flag    = flag_q;
  assign pending = flag_q | level_on;
endmodule

// File: rtl/extint_regfile.sv
module extint_regfile #(
  parameter int NPINS  = 8,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NPINS-1:0]  pending,
  output logic [2*NPINS-1:0] cfg,
  output logic [NPINS-1:0]  clr,
  output logic [NPINS-1:0]  seen,
  output logic [DATA_W-1:0] rdata
);
  localparam int CFG_W = 2 * NPINS;
  localparam logic [ADDR_W-1:0] OFF_CFG  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(2);

  logic [CFG_W-1:0]  cfg_q;
  logic [NPINS-1:0]  seen_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;
  logic sel_cfg, sel_stat;

  assign sel_cfg  = (addr == OFF_CFG);
  assign sel_stat = (addr == OFF_STAT);

  always_comb begin
    if (sel_cfg)       rd_mux = DATA_W'(cfg_q);
    else if (sel_stat) rd_mux = DATA_W'(pending);
    else               rd_mux = '0;
  end

  assign clr = (wr && sel_stat) ? (~wdata[NPINS-1:0] & seen_q) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      seen_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (wr && sel_cfg) cfg_q <= wdata[CFG_W-1:0];
      if (wr && sel_stat)      seen_q <= '0;
      else if (rd && sel_stat) seen_q <= pending;
      if (rd) rdata_q <= rd_mux;
    end
  end

  assign cfg   = cfg_q;
  assign seen  = seen_q;
  assign rdata = rdata_q;
endmodule

// File: rtl/extint_sense_ctrl.sv
module extint_sense_ctrl #(
  parameter int NPINS  = 8,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  irq_req
);
  logic [NPINS-1:0]   pin_cur, pin_prev;
  logic [NPINS-1:0]   edge_flag, pending, clr_vec, seen_mask;
  logic [2*NPINS-1:0] cfg_word;
  logic [NPINS-1:0]   irq_q;

  extint_sync #(.WIDTH(NPINS)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in), .cur(pin_cur), .prev(pin_prev)
  );

  extint_regfile #(.NPINS(NPINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .addr(reg_addr), .rd(reg_rd), .wr(reg_wr),
    .wdata(reg_wdata), .pending(pending), .cfg(cfg_word), .clr(clr_vec),
    .seen(seen_mask), .rdata(reg_rdata)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    extint_sense_cell u_cell (
      .clk(clk), .rst(rst), .mode(cfg_word[2*i+1:2*i]),
      .cur(pin_cur[i]), .prev(pin_prev[i]), .clr(clr_vec[i]),
      .flag(edge_flag[i]), .pending(pending[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= pending;
  end

  assign irq_req = irq_q;
endmodule

// File: rtl/extint_sense_ctrl_chk.sv
module extint_sense_ctrl_chk #(
  parameter int NPINS  = 8,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [NPINS-1:0]  irq_req,
  input logic [NPINS-1:0]  flag,
  input logic [NPINS-1:0]  seen,
  input logic [NPINS-1:0]  pending,
  input logic [2*NPINS-1:0] cfg
);
  logic wr_stat, wr_cfg, rd_stat;
  assign wr_stat = reg_wr && (reg_addr == ADDR_W'(2));
  assign wr_cfg  = reg_wr && (reg_addr == ADDR_W'(0));
  assign rd_stat = reg_rd && (reg_addr == ADDR_W'(2));

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (irq_req == '0 && reg_rdata == '0)); // R1

  AST_CFG_STORE: assert property (@(posedge clk) disable iff (rst)
    wr_cfg |=> (cfg == $past(reg_wdata[2*NPINS-1:0]))); // R2

  AST_ONE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    wr_stat |=> ((flag & $past(flag & reg_wdata[NPINS-1:0]))
                 == $past(flag & reg_wdata[NPINS-1:0]))); // R5

  AST_UNSEEN_KEEPS: assert property (@(posedge clk) disable iff (rst)
    wr_stat |=> ((flag & $past(flag & ~seen)) == $past(flag & ~seen))); // R6

  AST_MODE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (wr_cfg && !wr_stat) |=> ((flag & $past(flag)) == $past(flag))); // R7

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq_req == $past(pending)); // R8

  AST_STAT_UPPER: assert property (@(posedge clk) disable iff (rst)
    rd_stat |=> (reg_rdata[DATA_W-1:NPINS] == '0)); // R9
endmodule

bind extint_sense_ctrl extint_sense_ctrl_chk #(
  .NPINS(NPINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rd(reg_rd),
  .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .irq_req(irq_req), .flag(edge_flag), .seen(seen_mask),
  .pending(pending), .cfg(cfg_word)
);

// File: tb/extint_sense_ctrl_bench.sv
module extint_sense_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  reg_addr = '0;
  logic        reg_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [7:0]  pin_in = 8'hFF;
  logic [7:0]  irq_req;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #10 clk = ~clk; // 50 MHz

  extint_sense_ctrl u_extint_sense_ctrl (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .irq_req(irq_req)
  );

  // behavioural reference model
  logic [7:0]  m_s1, m_s2, m_s3, m_flag, m_seen, m_irq, pend, nflag;
  logic [15:0] m_cfg, m_rdata;
  int md;
  bit hit;

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = '1; m_s2 = '1; m_s3 = '1;
      m_flag = '0; m_seen = '0; m_irq = '0; m_cfg = '0; m_rdata = '0;
    end else begin
      for (int i = 0; i < 8; i++) begin
        md = int'((m_cfg >> (2*i)) & 16'h3);
        pend[i] = m_flag[i] | ((md == 0) && !m_s2[i]);
        case (md)
          1: hit = !m_s2[i] && m_s3[i];
          2: hit = m_s2[i] && !m_s3[i];
          3: hit = m_s2[i] != m_s3[i];
          default: hit = 1'b0;
        endcase
        if (hit) nflag[i] = 1'b1;
        else if (reg_wr && reg_addr == 2 && !reg_wdata[i] && m_seen[i]) nflag[i] = 1'b0;
        else nflag[i] = m_flag[i];
      end
      if (reg_rd)
        m_rdata = (reg_addr == 0) ? m_cfg : (reg_addr == 2) ? {8'h00, pend} : 16'h0;
      if (reg_wr && reg_addr == 2) m_seen = '0;
      else if (reg_rd && reg_addr == 2) m_seen = pend;
      if (reg_wr && reg_addr == 0) m_cfg = reg_wdata;
      m_irq = pend;
      m_flag = nflag;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(irq_req === m_irq, "R8 irq vs model", {8'h0, irq_req}, {8'h0, m_irq});
      chk(reg_rdata === m_rdata, "R9 rdata vs model", reg_rdata, m_rdata);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; v = reg_rdata;
  endtask

  task automatic do_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [15:0] v;
    // R1 / R10: reset with pins high
    repeat (3) @(negedge clk);
    chk(irq_req === 8'h00, "R1 irq in reset", {8'h0, irq_req}, 16'h0);
    chk(reg_rdata === 16'h0, "R1 rdata in reset", reg_rdata, 16'h0);
    rst = 1'b0;
    idle(4);
    chk(irq_req === 8'h00, "R10 no event after reset", {8'h0, irq_req}, 16'h0);
    do_read(2'd0, v); chk(v === 16'h0000, "R1 cfg reset", v, 16'h0000);
    do_read(2'd2, v); chk(v === 16'h0000, "R1 status reset", v, 16'h0000);

    // R3 / R8: low level on pin 3
    pin_in[3] = 1'b0; idle(4);
    chk(irq_req === 8'h08, "R3 low level pending", {8'h0, irq_req}, 16'h0008);
    do_read(2'd2, v); chk(v === 16'h0008, "R3 status shows level", v, 16'h0008);
    idle(3);
    chk(irq_req === 8'h08, "R8 request held", {8'h0, irq_req}, 16'h0008);
    pin_in[3] = 1'b1; idle(4);
    chk(irq_req === 8'h00, "R3 self clear", {8'h0, irq_req}, 16'h0);

    // R4: pin0 rising, pin1 falling
    do_write(2'd0, 16'h0006);
    pin_in[0] = 1'b0; idle(4);
    chk(irq_req === 8'h00, "R4 rising mode ignores fall", {8'h0, irq_req}, 16'h0);
    pin_in[0] = 1'b1; idle(4);
    chk(irq_req === 8'h01, "R4 rising edge latched", {8'h0, irq_req}, 16'h0001);

    // R6: zero write without prior read keeps bit
    do_write(2'd2, 16'hFFFE); idle(2);
    do_read(2'd2, v); chk(v === 16'h0001, "R6 unseen bit kept", v, 16'h0001);
    // R5: ones keep bit
    do_write(2'd2, 16'hFFFF);
    do_read(2'd2, v); chk(v === 16'h0001, "R5 one write keeps", v, 16'h0001);
    // R6: edge after read survives
    pin_in[1] = 1'b0; idle(4);
    do_write(2'd2, 16'h0000);
    do_read(2'd2, v); chk(v === 16'h0002, "R6 late edge survives, seen cleared", v, 16'h0002);

    // R7: mode change keeps latched bit (pin1 to rising)
    do_write(2'd0, 16'h000A);
    do_read(2'd2, v); chk(v === 16'h0002, "R7 mode change keeps", v, 16'h0002);
    do_write(2'd2, 16'hFFFD);
    do_read(2'd2, v); chk(v === 16'h0000, "R6 read then write clears", v, 16'h0000);
    pin_in[1] = 1'b1; idle(4);
    do_read(2'd2, v); chk(v === 16'h0002, "R4 rising on pin1", v, 16'h0002);
    do_write(2'd2, 16'hFFFD); idle(2);

    // R4: both edges on pin2
    do_write(2'd0, 16'h0030);
    pin_in[2] = 1'b0; idle(4);
    do_read(2'd2, v); chk(v === 16'h0004, "R4 both: fall", v, 16'h0004);
    do_write(2'd2, 16'hFFFB);
    do_read(2'd2, v); chk(v === 16'h0000, "R4 both cleared", v, 16'h0000);
    pin_in[2] = 1'b1; idle(4);
    do_read(2'd2, v); chk(v === 16'h0004, "R4 both: rise", v, 16'h0004);
    do_write(2'd2, 16'hFFFB); idle(2);

    // R2: configuration read-modify-write
    do_write(2'd0, 16'h1234);
    do_read(2'd0, v); chk(v === 16'h1234, "R2 cfg readback", v, 16'h1234);
    do_write(2'd0, (v & ~16'hC000) | 16'hC000);
    do_read(2'd0, v); chk(v === 16'hD234, "R2 field update", v, 16'hD234);

    // R9: unmapped offset and upper status byte
    do_write(2'd1, 16'hFFFF);
    do_read(2'd1, v); chk(v === 16'h0000, "R9 unmapped reads zero", v, 16'h0000);
    do_read(2'd0, v); chk(v === 16'hD234, "R9 unmapped write ignored", v, 16'hD234);
    do_read(2'd2, v); chk(v[15:8] === 8'h00, "R9 status upper zero", v, {8'h00, v[7:0]});

    idle(3);
    finish_run();
  end
endmodule